// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Frame

This block is a 4 KB memory-mapped register frame that converts doorbell writes into interrupt pulses. A device or bridge signals an interrupt by writing an interrupt number to a single set register. The block takes the low ten bits of that value and subtracts the frame's first interrupt number, which is the configured base plus 32. If the result falls inside the configured window, the block pulses the matching bit of its output vector for one clock. The block chooses the output line from the value written, not from the address. Numbers outside the window are dropped without any response.

Software discovers the window by reading a type register, which holds the first interrupt number in its upper half and the line count in its lower half. The frame also holds an interface identification word and a block of identification offsets that all read as zero. The bus is a simple 32-bit little-endian slave with byte strobes. Every request gets a registered response one cycle later. An access to an undefined offset, or an access of an unsupported size, completes normally but raises a one-cycle error flag.

The window is set by two parameters, `BASE_IRQ` and `LINE_COUNT`. Elaboration stops if the count exceeds 128 or if the window would reach past interrupt number 1019.

Top module: `msi_doorbell_frame`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `bus_ready`, `bus_err`, `bus_rdata` and every bit of `irq_pulse` are zero.
- R2: Each cycle with `bus_sel` high produces `bus_ready` high in exactly the next cycle. A cycle without `bus_sel` produces `bus_ready` low in the next cycle.
- R3: A full-word read (`bus_strb` = 4'b1111) of byte offset 0x008 returns ((BASE_IRQ + 32) << 16) | LINE_COUNT with no error.
- R4: A full-word read of offset 0xFCC returns 0x0510_0000, which is 0x51 in bits [31:20] with all other fields zero, and raises no error.
- R5: A full-word read of any word-aligned offset from 0xFD0 to 0xFFC returns zero and raises no error.
- R6: A write to offset 0x040 with `bus_strb` 4'b1111 or 4'b0011 takes ID = `bus_wdata[9:0]` and ignores the upper bits. If BASE_IRQ+32 <= ID < BASE_IRQ+32+LINE_COUNT, bit ID-(BASE_IRQ+32) of `irq_pulse` is high for exactly the cycle in which `bus_ready` answers that write. No other bit is high in that cycle.
- R7: A doorbell write whose ID lies outside the window pulses no line and raises no error.
- R8: Doorbell writes in back-to-back cycles each produce their pulse in their own response cycle. Two writes to the same line hold that bit high for two cycles, and it falls in the cycle after.
- R9: A read with any `bus_strb` other than 4'b1111 returns zero and raises `bus_err` in its response cycle.
- R10: A write with `bus_strb` other than 4'b1111 or 4'b0011 is ignored (no pulse) and raises `bus_err`.
- R11: A read of an undefined offset returns zero with `bus_err`. This includes offset 0x040 and any offset that is not word-aligned. A write to any offset other than 0x040 pulses nothing and raises `bus_err`. A strobe of 4'b1100 at 0x040 counts as an access to offset 0x042.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_strb | input | 4 | Byte lane enables; lane 0 = bits [7:0] |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Response for the previous cycle's request |
| bus_err | output | 1 | Error flag, one cycle, with bus_ready |
| irq_pulse | output | LINE_COUNT | One-clock interrupt pulses |

## Verification
The bench builds the frame with BASE_IRQ = 8 and LINE_COUNT = 100. This puts the window at interrupt numbers 40 through 139 and makes the type register read 0x0028_0064. Because neither parameter is at its default, a design that ignores the base or the +32 offset is caught. The count is also not a power of two, so a check that accepts all IDs up to the next power of two is exposed. These values place the edge IDs 39, 40, 139 and 140, the largest ten-bit ID 1023, and an ID hidden under set upper data bits all at clear expected outcomes.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int ID_W   = 10;

    localparam logic [ADDR_W-1:0] OFS_TYPE     = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_DOORBELL = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_IFACE    = 12'hFCC;
    localparam logic [ADDR_W-1:0] OFS_IDBLK_LO = 12'hFD0;
    localparam logic [ADDR_W-1:0] OFS_IDBLK_HI = 12'hFFC;

    localparam logic [7:0]  IFACE_PRODUCT = 8'h51;
    localparam int          IFACE_SHIFT   = 20;

    localparam logic [STRB_W-1:0] STRB_WORD = 4'b1111;
    localparam logic [STRB_W-1:0] STRB_HALF = 4'b0011;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_TYPE,
        RK_DOORBELL,
        RK_IFACE,
        RK_IDBLK
    } reg_kind_e;

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
    import msi_frame_pkg::*;
(
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [STRB_W-1:0] strb,
    output reg_kind_e         kind,
    output logic              access_ok
);

    logic aligned;
    logic size_ok;

    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        kind    = RK_NONE;
        if (aligned) begin
            if (we) begin
                if (addr == OFS_DOORBELL) kind = RK_DOORBELL;
            end else begin
                if (addr == OFS_TYPE)
                    kind = RK_TYPE;
                else if (addr == OFS_IFACE)
                    kind = RK_IFACE;
                else if (addr >= OFS_IDBLK_LO && addr <= OFS_IDBLK_HI)
                    kind = RK_IDBLK;
            end
        end
        if (we)
            size_ok = (strb == STRB_WORD) || (strb == STRB_HALF);
        else
            size_ok = (strb == STRB_WORD);
        access_ok = size_ok && (kind != RK_NONE);
    end

endmodule

// File: rtl/msi_id_window.sv
module msi_id_window
    import msi_frame_pkg::*;
#(
    parameter int BASE_IRQ   = 0,
    parameter int LINE_COUNT = 64
) (
    input  logic [ID_W-1:0]       id,
    output logic [LINE_COUNT-1:0] hit
);

    localparam int FIRST_ID = BASE_IRQ + 32;

    for (genvar i = 0; i < LINE_COUNT; i++) begin : g_line
        localparam logic [ID_W-1:0] LINE_ID = ID_W'(FIRST_ID + i);
        assign hit[i] = (id == LINE_ID);
    end

endmodule

// File: rtl/msi_read_mux.sv
module msi_read_mux
    import msi_frame_pkg::*;
#(
    parameter int BASE_IRQ   = 0,
    parameter int LINE_COUNT = 64
) (
    input  reg_kind_e         kind,
    output logic [DATA_W-1:0] data
);

    localparam logic [DATA_W-1:0] TYPE_WORD =
        (DATA_W'(BASE_IRQ + 32) << 16) | DATA_W'(LINE_COUNT);
    localparam logic [DATA_W-1:0] IFACE_WORD =
        DATA_W'(IFACE_PRODUCT) << IFACE_SHIFT;

    always_comb begin
        unique case (kind)
            RK_TYPE:  data = TYPE_WORD;
            RK_IFACE: data = IFACE_WORD;
            default:  data = '0;
        endcase
    end

endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
    import msi_frame_pkg::*;
#(
    parameter int BASE_IRQ   = 0,
    parameter int LINE_COUNT = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [11:0]           bus_addr,
    input  logic [31:0]           bus_wdata,
    input  logic [3:0]            bus_strb,
    output logic [31:0]           bus_rdata,
    output logic                  bus_ready,
    output logic                  bus_err,
    output logic [LINE_COUNT-1:0] irq_pulse
);

    localparam int MAX_LINES = 128;
    localparam int ID_LIMIT  = 1020;

    if (LINE_COUNT < 1 || LINE_COUNT > MAX_LINES) begin : g_bad_count
        $error("msi_doorbell_frame: LINE_COUNT out of range");
    end
    if (BASE_IRQ < 0 || BASE_IRQ + 32 > ID_LIMIT - LINE_COUNT) begin : g_bad_base
        $error("msi_doorbell_frame: interrupt window exceeds ID limit");
    end

    typedef struct packed {
        logic                  ready;
        logic                  err;
        logic [DATA_W-1:0]     rdata;
        logic [LINE_COUNT-1:0] pulse;
    } frame_state_t;

    frame_state_t st_d, st_q;

    reg_kind_e             kind;
    logic                  access_ok;
    logic [DATA_W-1:0]     rd_word;
    logic [LINE_COUNT-1:0] line_hit;
    logic                  unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:ID_W];

    msi_addr_decode u_decode (
        .we        (bus_we),
        .addr      (bus_addr),
        .strb      (bus_strb),
        .kind      (kind),
        .access_ok (access_ok)
    );

    msi_id_window #(
        .BASE_IRQ   (BASE_IRQ),
        .LINE_COUNT (LINE_COUNT)
    ) u_window (
        .id  (bus_wdata[ID_W-1:0]),
        .hit (line_hit)
    );

    msi_read_mux #(
        .BASE_IRQ   (BASE_IRQ),
        .LINE_COUNT (LINE_COUNT)
    ) u_rdmux (
        .kind (kind),
        .data (rd_word)
    );

    always_comb begin
        st_d       = '0;
        st_d.ready = bus_sel;
        if (bus_sel) begin
            st_d.err = !access_ok;
            if (access_ok) begin
                if (bus_we) begin
                    if (kind == RK_DOORBELL) st_d.pulse = line_hit;
                end else begin
                    st_d.rdata = rd_word;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_ready = st_q.ready;
    assign bus_err   = st_q.err;
    assign bus_rdata = st_q.rdata;
    assign irq_pulse = st_q.pulse;

endmodule

// File: rtl/msi_doorbell_frame_chk.sv
module msi_doorbell_frame_chk #(
    parameter int LINE_COUNT = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_we,
    input logic [31:0]           bus_rdata,
    input logic                  bus_ready,
    input logic                  bus_err,
    input logic [LINE_COUNT-1:0] irq_pulse
);

    assert_ready_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ready);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (!bus_ready && !bus_err && irq_pulse == '0));

    assert_single_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_pulse));

    assert_pulse_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> (irq_pulse == '0));

    assert_err_blocks_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (irq_pulse == '0));

    assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0 && bus_ready));

    assert_write_no_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we) |=> (bus_rdata == '0));

endmodule

bind msi_doorbell_frame msi_doorbell_frame_chk #(
    .LINE_COUNT (LINE_COUNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .irq_pulse (irq_pulse)
);

// File: tb/msi_doorbell_frame_tb.sv
module msi_doorbell_frame_tb;

    localparam int BASE  = 8;
    localparam int LINES = 100;
    localparam int NVEC  = 22;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             bus_sel;
    logic             bus_we;
    logic [11:0]      bus_addr;
    logic [31:0]      bus_wdata;
    logic [3:0]       bus_strb;
    logic [31:0]      bus_rdata;
    logic             bus_ready;
    logic             bus_err;
    logic [LINES-1:0] irq_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    msi_doorbell_frame #(
        .BASE_IRQ   (BASE),
        .LINE_COUNT (LINES)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_strb  (bus_strb),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .bus_err   (bus_err),
        .irq_pulse (irq_pulse)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [11:0] addr;
        logic [3:0]  strb;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic        err;
        logic        hit;
        logic [7:0]  line;
    } vec_t;

    // window for BASE=8, LINES=100: IDs 40..139
    localparam vec_t VECS [NVEC] = '{
        '{4'd3,  1'b0, 12'h008, 4'hF, 32'h0, 32'h0028_0064, 1'b0, 1'b0, 8'd0},  // R3
        '{4'd4,  1'b0, 12'hFCC, 4'hF, 32'h0, 32'h0510_0000, 1'b0, 1'b0, 8'd0},  // R4
        '{4'd5,  1'b0, 12'hFD0, 4'hF, 32'h0, 32'h0,         1'b0, 1'b0, 8'd0},  // R5
        '{4'd5,  1'b0, 12'hFE8, 4'hF, 32'h0, 32'h0,         1'b0, 1'b0, 8'd0},  // R5
        '{4'd5,  1'b0, 12'hFFC, 4'hF, 32'h0, 32'h0,         1'b0, 1'b0, 8'd0},  // R5
        '{4'd6,  1'b1, 12'h040, 4'hF, 32'd40,  32'h0, 1'b0, 1'b1, 8'd0},        // R6
        '{4'd6,  1'b1, 12'h040, 4'hF, 32'd139, 32'h0, 1'b0, 1'b1, 8'd99},       // R6
        '{4'd6,  1'b1, 12'h040, 4'h3, 32'd65,  32'h0, 1'b0, 1'b1, 8'd25},       // R6
        '{4'd6,  1'b1, 12'h040, 4'hF, 32'hFFFF_FC32, 32'h0, 1'b0, 1'b1, 8'd10}, // R6
        '{4'd7,  1'b1, 12'h040, 4'hF, 32'd39,   32'h0, 1'b0, 1'b0, 8'd0},       // R7
        '{4'd7,  1'b1, 12'h040, 4'hF, 32'd140,  32'h0, 1'b0, 1'b0, 8'd0},       // R7
        '{4'd7,  1'b1, 12'h040, 4'hF, 32'd1023, 32'h0, 1'b0, 1'b0, 8'd0},       // R7
        '{4'd9,  1'b0, 12'h008, 4'h3, 32'h0, 32'h0, 1'b1, 1'b0, 8'd0},          // R9
        '{4'd9,  1'b0, 12'hFCC, 4'h0, 32'h0, 32'h0, 1'b1, 1'b0, 8'd0},          // R9
        '{4'd10, 1'b1, 12'h040, 4'h1, 32'd40, 32'h0, 1'b1, 1'b0, 8'd0},         // R10
        '{4'd10, 1'b1, 12'h040, 4'hC, 32'd40, 32'h0, 1'b1, 1'b0, 8'd0},         // R10
        '{4'd11, 1'b0, 12'h040, 4'hF, 32'h0,  32'h0, 1'b1, 1'b0, 8'd0},         // R11
        '{4'd11, 1'b0, 12'h004, 4'hF, 32'h0,  32'h0, 1'b1, 1'b0, 8'd0},         // R11
        '{4'd11, 1'b1, 12'h008, 4'hF, 32'd40, 32'h0, 1'b1, 1'b0, 8'd0},         // R11
        '{4'd11, 1'b1, 12'h044, 4'hF, 32'd40, 32'h0, 1'b1, 1'b0, 8'd0},         // R11
        '{4'd11, 1'b0, 12'h00A, 4'hF, 32'h0,  32'h0, 1'b1, 1'b0, 8'd0},         // R11
        '{4'd11, 1'b1, 12'hFCC, 4'hF, 32'd40, 32'h0, 1'b1, 1'b0, 8'd0}          // R11
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // drive at a falling edge, look at the response one falling edge later
    task automatic request(input logic we, input logic [11:0] addr,
                           input logic [3:0] strb, input logic [31:0] wdata);
        bus_sel   = 1'b1;
        bus_we    = we;
        bus_addr  = addr;
        bus_strb  = strb;
        bus_wdata = wdata;
        @(negedge clk);
        bus_sel   = 1'b0;
    endtask

    function automatic logic [LINES-1:0] line_vec(input bit hit, input int line);
        logic [LINES-1:0] v = '0;
        if (hit) v[line] = 1'b1;
        return v;
    endfunction

    initial begin
        rst_n     = 1'b0;
        bus_sel   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_strb  = '0;
        bus_wdata = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(bus_ready == 1'b0 && bus_err == 1'b0, "R1", "ready/err in reset",
              {bus_ready, bus_err}, 0);
        check(bus_rdata == '0 && irq_pulse == '0, "R1", "data/pulse in reset",
              irq_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_ready == 1'b0 && irq_pulse == '0, "R1", "first cycle after reset",
              {bus_ready, irq_pulse}, 0);

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            logic [LINES-1:0] exp_p;
            tag   = $sformatf("R%0d", VECS[i].req);
            exp_p = line_vec(VECS[i].hit, int'(VECS[i].line));
            request(VECS[i].we, VECS[i].addr, VECS[i].strb, VECS[i].wdata);
            check(bus_ready == 1'b1, "R2", $sformatf("ready vec %0d", i), bus_ready, 1);
            check(bus_err == VECS[i].err, tag, $sformatf("err vec %0d", i),
                  bus_err, VECS[i].err);
            check(bus_rdata == VECS[i].rdata, tag, $sformatf("rdata vec %0d", i),
                  bus_rdata, VECS[i].rdata);
            check(irq_pulse == exp_p, tag, $sformatf("pulse vec %0d", i),
                  irq_pulse, exp_p);
        end

        // R2 idle cycle gives no response; R6 pulse lasts one cycle
        @(negedge clk);
        check(bus_ready == 1'b0 && irq_pulse == '0, "R2", "idle cycle",
              {bus_ready, irq_pulse}, 0);

        // R8 back-to-back writes to the same line, then a different line
        request(1'b1, 12'h040, 4'hF, 32'd45);
        check(irq_pulse == line_vec(1, 5), "R8", "first of pair", irq_pulse, line_vec(1, 5));
        request(1'b1, 12'h040, 4'hF, 32'd45);
        check(irq_pulse == line_vec(1, 5), "R8", "second of pair", irq_pulse, line_vec(1, 5));
        request(1'b1, 12'h040, 4'h3, 32'd46);
        check(irq_pulse == line_vec(1, 6), "R8", "next line", irq_pulse, line_vec(1, 6));
        @(negedge clk);
        check(irq_pulse == '0, "R8", "line falls after", irq_pulse, 0);

        // R1 reset taken while a pulse would be produced
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h040; bus_strb = 4'hF;
        bus_wdata = 32'd50;
        rst_n = 1'b0;
        @(negedge clk);
        bus_sel = 1'b0;
        check(irq_pulse == '0 && bus_ready == 1'b0, "R1", "reset beats doorbell",
              {bus_ready, irq_pulse}, 0);
        rst_n = 1'b1;
        request(1'b0, 12'h008, 4'hF, 32'h0);
        check(bus_rdata == 32'h0028_0064, "R3", "type after reset", bus_rdata, 32'h0028_0064);

        done = 1'b1;
        finish_run();
    end

    initial begin
        int cycles = 0;
        while (!done && cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<5000 cycles", cycles);
            finish_run();
        end
    end

endmodule